// File: doc/BRIEF.md
# Instruction word packer

This block takes a stream of instructions of two sizes, a short one that fills one 15-bit slot and a long one that fills two, and packs them into 60-bit words of four slots each. Short and long instructions may share a word in any mix. A long instruction is never split across two words. When a long instruction arrives and only the last slot of the current word is free, the packer puts a no-op in that slot, sends the word out, and starts the long instruction at the first slot of the next word. All of this happens in one input handshake.

Instructions enter through a valid/ready handshake that carries a length flag and a 30-bit payload. Packed words leave through a valid/ready stream backed by one output register. A flush request fills the free slots of a partly filled word with no-ops and sends that word out. Two saturating counters report how many instructions were accepted and how many no-ops were inserted, so the padding overhead can be measured.

Top module: `parcel_packer`

## Requirements
- R1: After reset, out_valid is 0, both counters read 0, and the next instruction goes into slot 0 of an empty word.
- R2: Slot 0 is out_word[59:45], and the slots fill in order toward bit 0. A short instruction (in_long=0) takes in_data[14:0] into the next free slot, and in_data[29:15] is ignored.
- R3: A long instruction (in_long=1) takes two adjacent slots when at least two are free: in_data[29:15] goes into the first slot and in_data[14:0] into the second.
- R4: A word is presented on out_valid/out_word on the clock edge after the handshake that fills its fourth slot.
- R5: A long instruction accepted when exactly one slot is free puts the no-op code in slot 3, emits that word, and places the long instruction in slots 0 and 1 of the next word, all in one handshake.
- R6: A flush is taken in a cycle with flush=1, in_valid=0 and in_ready=1. It fills every free slot with the no-op code and emits the word. A flush while the word is empty emits nothing, and flush has no effect while in_valid is 1.
- R7: While out_valid=1 and out_ready=0, out_word holds its value and in_ready is 0.
- R8: insn_count goes up by one for each accepted instruction, short or long, and stays at its all-ones maximum once it gets there.
- R9: nop_count goes up by the number of no-op slots inserted, whether by a split or by a flush, and saturates at all ones.
- R10: Every inserted slot carries the NOP_CODE parameter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_long | input | 1 | 1 = two-slot instruction, 0 = one-slot instruction |
| in_data | input | 30 | Instruction payload (short uses bits 14:0) |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| flush | input | 1 | Pad and emit the partial word |
| out_valid | output | 1 | Packed word available |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 60 | Packed word, slot 0 in the top bits |
| insn_count | output | 32 | Accepted instructions, saturating |
| nop_count | output | 32 | Inserted no-op slots, saturating |

## Verification
The checker assumes that a consumer may stall for any number of cycles. It also assumes that reset is held for at least one edge, and its checks of counter steps only start one cycle after reset is released. The bench holds flush only while in_valid is low, except in the single case that tests whether flush is ignored, where the two are raised together. It keeps the upper payload bits of short instructions non-zero so that a leak into the word would show. It sweeps every short/long sequence of length one to six, with and without output stalls, and runs long sequences to drive both counters into saturation on a 6-bit counter configuration.

// File: rtl/parcel_pkg.sv
// Shared types for the instruction word packer.
package parcel_pkg;
    // Action chosen for the current cycle by the slot controller.
    typedef enum logic [2:0] {
        ACT_IDLE,   // nothing placed
        ACT_SHORT,  // one-slot instruction placed
        ACT_LONG,   // two-slot instruction placed in the current word
        ACT_SPLIT,  // last slot padded, long instruction moved to next word
        ACT_FLUSH   // free slots padded, partial word emitted
    } pk_act_e;
endpackage

// File: rtl/pk_slot_ctrl.sv
// Slot controller: tracks how many slots of the current word are filled and
// decides per cycle whether to place, split, or flush, and whether a word is
// emitted. Assumes SLOTS >= 3 so a split always leaves room for the long
// instruction in the next word.
module pk_slot_ctrl
    import parcel_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int PW    = 2,
    localparam int FW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          is_long,
    input  logic          flush_ok,
    output logic [PW-1:0] ptr,
    output pk_act_e       act,
    output logic          emit,
    output logic [FW-1:0] pad_cnt
);
    logic [PW-1:0] ptr_q, ptr_d;
    logic [FW-1:0] ptr_x, fill;

    assign ptr_x = {1'b0, ptr_q};
    assign ptr   = ptr_q;

    // Choose the action, the fill level and the pointer for the next cycle.
    always_comb begin
        act     = ACT_IDLE;
        fill    = ptr_x;
        pad_cnt = '0;
        emit    = 1'b0;
        ptr_d   = ptr_q;
        if (accept && !is_long) begin
            act  = ACT_SHORT;
            fill = ptr_x + FW'(1);
        end else if (accept && is_long && (ptr_x <= FW'(SLOTS - 2))) begin
            act  = ACT_LONG;
            fill = ptr_x + FW'(2);
        end else if (accept && is_long) begin
            act     = ACT_SPLIT;
            pad_cnt = FW'(1);
            emit    = 1'b1;
            ptr_d   = PW'(2);
        end else if (flush_ok && (ptr_q != '0)) begin
            act     = ACT_FLUSH;
            pad_cnt = FW'(SLOTS) - ptr_x;
            emit    = 1'b1;
            ptr_d   = '0;
        end
        if ((act == ACT_SHORT) || (act == ACT_LONG)) begin
            if (fill == FW'(SLOTS)) begin
                emit  = 1'b1;
                ptr_d = '0;
            end else begin
                ptr_d = fill[PW-1:0];
            end
        end
    end

    // Slot pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end
endmodule

// File: rtl/pk_word_build.sv
// Word builder: holds the partially filled word, one register per slot, and
// forms the combined word for this cycle from the held slots, the incoming
// payload and the no-op code. Slot 0 maps to the most significant bits.
module pk_word_build
    import parcel_pkg::*;
#(
    parameter int SLOT_W = 15,
    parameter int SLOTS  = 4,
    parameter int PW     = 2,
    parameter logic [SLOT_W-1:0] NOP_CODE = '0,
    localparam int FW     = PW + 1,
    localparam int WORD_W = SLOT_W * SLOTS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PW-1:0]       ptr,
    input  pk_act_e             act,
    input  logic                emit,
    input  logic [2*SLOT_W-1:0] data,
    output logic [WORD_W-1:0]   word_out
);
    logic [SLOT_W-1:0] hi, lo;
    logic [FW-1:0]     ptr_x, ptr_n;

    assign hi    = data[2*SLOT_W-1:SLOT_W];
    assign lo    = data[SLOT_W-1:0];
    assign ptr_x = {1'b0, ptr};
    assign ptr_n = ptr_x + FW'(1);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        localparam logic [FW-1:0] SIDX = FW'(s);
        logic [SLOT_W-1:0] held_q, comb, nxt;

        // Content of this slot in the word formed this cycle.
        always_comb begin
            comb = held_q;
            case (act)
                ACT_SHORT: if (ptr_x == SIDX) comb = lo;
                ACT_LONG: begin
                    if (ptr_x == SIDX)      comb = hi;
                    else if (ptr_n == SIDX) comb = lo;
                end
                ACT_SPLIT, ACT_FLUSH: if (SIDX >= ptr_x) comb = NOP_CODE;
                default: comb = held_q;
            endcase
        end

        // Value held for the next cycle: restart after emit, else keep.
        always_comb begin
            if (emit) begin
                if ((act == ACT_SPLIT) && (s == 0))      nxt = hi;
                else if ((act == ACT_SPLIT) && (s == 1)) nxt = lo;
                else                                     nxt = NOP_CODE;
            end else begin
                nxt = comb;
            end
        end

        // Slot holding register.
        always_ff @(posedge clk) begin
            if (!rst_n) held_q <= '0;
            else        held_q <= nxt;
        end

        assign word_out[(SLOTS-s)*SLOT_W-1 -: SLOT_W] = comb;
    end
endmodule

// File: rtl/pk_sat_counter.sv
// Saturating up-counter with a variable increment. Assumes IW <= W + 1.
module pk_sat_counter #(
    parameter int W  = 32,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] inc,
    output logic [W-1:0]  count
);
    logic [W:0] sum;

    // Add with one guard bit to detect overflow.
    always_comb sum = {1'b0, count} + (W+1)'(inc);

    // Counter register, clamps at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (sum[W]) count <= '1;
        else             count <= sum[W-1:0];
    end
endmodule

// File: rtl/parcel_packer.sv
// Instruction word packer top level. Accepts one- or two-slot instructions
// over valid/ready, packs them into SLOTS-slot words without splitting a
// two-slot instruction, and emits words through one output register.
// Assumes flush is only meaningful while in_valid is low.
module parcel_packer #(
    parameter int SLOT_W = 15,
    parameter int SLOTS  = 4,
    parameter logic [SLOT_W-1:0] NOP_CODE = '0,
    parameter int CNT_W  = 32,
    localparam int WORD_W = SLOT_W * SLOTS,
    localparam int PW     = $clog2(SLOTS),
    localparam int FW     = PW + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_long,
    input  logic [2*SLOT_W-1:0] in_data,
    output logic                in_ready,
    input  logic                flush,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [WORD_W-1:0]   out_word,
    output logic [CNT_W-1:0]    insn_count,
    output logic [CNT_W-1:0]    nop_count
);
    import parcel_pkg::*;

    logic              accept, flush_ok, emit;
    logic [PW-1:0]     ptr;
    pk_act_e           act;
    logic [FW-1:0]     pad_cnt;
    logic [WORD_W-1:0] word_now;
    logic              ovalid_q;
    logic [WORD_W-1:0] oword_q;

    assign in_ready  = !(ovalid_q && !out_ready);
    assign accept    = in_valid && in_ready;
    assign flush_ok  = flush && !in_valid && in_ready;
    assign out_valid = ovalid_q;
    assign out_word  = oword_q;

    pk_slot_ctrl #(.SLOTS(SLOTS), .PW(PW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .accept(accept), .is_long(in_long),
        .flush_ok(flush_ok), .ptr(ptr), .act(act), .emit(emit),
        .pad_cnt(pad_cnt)
    );

    pk_word_build #(.SLOT_W(SLOT_W), .SLOTS(SLOTS), .PW(PW),
                    .NOP_CODE(NOP_CODE)) u_build (
        .clk(clk), .rst_n(rst_n), .ptr(ptr), .act(act), .emit(emit),
        .data(in_data), .word_out(word_now)
    );

    pk_sat_counter #(.W(CNT_W), .IW(FW)) u_insn_cnt (
        .clk(clk), .rst_n(rst_n), .inc({{PW{1'b0}}, accept}),
        .count(insn_count)
    );

    pk_sat_counter #(.W(CNT_W), .IW(FW)) u_nop_cnt (
        .clk(clk), .rst_n(rst_n), .inc(pad_cnt), .count(nop_count)
    );

    // Output register: load on emit, clear once the consumer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovalid_q <= 1'b0;
            oword_q  <= '0;
        end else if (emit) begin
            ovalid_q <= 1'b1;
            oword_q  <= word_now;
        end else if (out_ready) begin
            ovalid_q <= 1'b0;
        end
    end
endmodule

// File: rtl/parcel_packer_chk.sv
// Checker for the packer ports. Step checks start one cycle after reset
// release so that $past never looks at a value from before reset.
module parcel_packer_chk #(
    parameter int WORD_W = 60,
    parameter int CNT_W  = 32,
    parameter int SLOTS  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_word,
    input logic [CNT_W-1:0]  insn_count,
    input logic [CNT_W-1:0]  nop_count
);
    logic seen_q;

    // Marks that one clean cycle has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        (in_valid && in_ready) |=>
            ((insn_count == CNT_W'($past(insn_count) + 1'b1)) || (&$past(insn_count))));

    assert_count_idle_R8: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        !(in_valid && in_ready) |=> $stable(insn_count));

    assert_nop_bound_R9: assert property (@(posedge clk) disable iff (!rst_n || !seen_q)
        seen_q |=> ((nop_count >= $past(nop_count)) &&
                    ((nop_count - $past(nop_count)) <= CNT_W'(SLOTS))));
endmodule

bind parcel_packer parcel_packer_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W), .SLOTS(SLOTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .insn_count(insn_count), .nop_count(nop_count)
);

// File: tb/sim_parcel_packer.sv
// Bench: sweeps every short/long sequence up to length 6, with and without
// output stalls, against an arithmetic packing model; then flush and
// saturation corners on a 6-bit counter configuration.
module sim_parcel_packer;
    localparam int SW = 15;
    localparam int NS = 4;
    localparam int CW = 6;
    localparam int CMAX = 63;
    localparam logic [SW-1:0] NOPV = 15'h5A5A;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_long = 1'b0, flush = 1'b0, out_ready = 1'b1;
    logic [2*SW-1:0] in_data = '0;
    logic in_ready, out_valid;
    logic [SW*NS-1:0] out_word;
    logic [CW-1:0] insn_count, nop_count;

    int errors = 0, checks = 0, uid = 0, cyc = 0;
    bit bp_en = 1'b0;

    logic [SW-1:0] ms [NS];
    int mp = 0, mnop = 0, mins = 0;
    logic [SW*NS-1:0] exq [$];
    bit stall_prev = 1'b0;
    logic [SW*NS-1:0] prev_word;

    parcel_packer #(.SLOT_W(SW), .SLOTS(NS), .NOP_CODE(NOPV), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_long(in_long),
        .in_data(in_data), .in_ready(in_ready), .flush(flush),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
        .insn_count(insn_count), .nop_count(nop_count)
    );

    always #5 clk = ~clk;

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int sat(int v);
        return (v > CMAX) ? CMAX : v;
    endfunction

    task automatic m_emit();
        exq.push_back({ms[0], ms[1], ms[2], ms[3]});
        mp = 0;
    endtask

    task automatic m_short(logic [SW-1:0] d);
        ms[mp] = d; mp++; mins = sat(mins + 1);
        if (mp == NS) m_emit();
    endtask

    task automatic m_long(logic [SW-1:0] h, logic [SW-1:0] l);
        if (mp == NS - 1) begin ms[NS-1] = NOPV; mnop = sat(mnop + 1); m_emit(); end
        ms[mp] = h; ms[mp+1] = l; mp += 2; mins = sat(mins + 1);
        if (mp == NS) m_emit();
    endtask

    task automatic m_flush();
        if (mp != 0) begin
            for (int k = mp; k < NS; k++) ms[k] = NOPV;
            mnop = sat(mnop + NS - mp);
            m_emit();
        end
    endtask

    // Output driver: optional stall pattern, changes away from the edge.
    always @(posedge clk) begin
        #2;
        cyc++;
        out_ready = !bp_en || ((cyc % 3) != 1);
    end

    // Monitor: R7 hold/stall and word comparison against the model queue.
    always @(negedge clk) begin
        if (!rst_n) begin
            stall_prev = 1'b0;
        end else begin
            if (stall_prev)
                chk(out_valid && (out_word == prev_word), "R7 word held under stall",
                    64'(out_word), 64'(prev_word));
            stall_prev = out_valid && !out_ready;
            prev_word  = out_word;
            if (stall_prev) chk(!in_ready, "R7 in_ready low under stall", 64'(in_ready), 64'd0);
            if (out_valid && out_ready) begin
                if (exq.size() == 0) chk(1'b0, "R4 unexpected word", 64'(out_word), 64'd0);
                else begin
                    logic [SW*NS-1:0] e;
                    e = exq.pop_front();
                    chk(out_word == e, "R2 R3 R4 R5 R10 packed word", 64'(out_word), 64'(e));
                end
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(!out_valid, "R1 out_valid after reset", 64'(out_valid), 64'd0);
        chk(insn_count == 0, "R1 insn_count after reset", 64'(insn_count), 64'd0);
        chk(nop_count == 0, "R1 nop_count after reset", 64'(nop_count), 64'd0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        mp = 0; mnop = 0; mins = 0; exq.delete();
    endtask

    task automatic send(bit lng);
        bit got;
        logic [SW-1:0] a, b;
        uid++;
        a = SW'(uid * 11 + 1);
        b = SW'(uid * 11 + 2);
        in_valid = 1'b1;
        in_long  = lng;
        in_data  = lng ? {a, b} : {~b, a};
        do begin
            @(negedge clk); got = in_ready;
            @(posedge clk); #2;
        end while (!got);
        in_valid = 1'b0;
        if (lng) m_long(a, b); else m_short(a);
    endtask

    task automatic do_flush();
        bit got;
        flush = 1'b1;
        do begin
            @(negedge clk); got = in_ready;
            @(posedge clk); #2;
        end while (!got);
        flush = 1'b0;
        m_flush();
    endtask

    task automatic drain_and_count();
        int n = 0;
        while ((exq.size() != 0 || out_valid) && n < 60) begin
            @(negedge clk); n++;
        end
        @(negedge clk);
        chk(exq.size() == 0, "R4 all words delivered", 64'(exq.size()), 64'd0);
        chk(insn_count == CW'(mins), "R8 insn_count", 64'(insn_count), 64'(mins));
        chk(nop_count == CW'(mnop), "R9 nop_count", 64'(nop_count), 64'(mnop));
        @(posedge clk); #2;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(10 * 150000);
        errors++; checks++;
        $display("FAIL R4 watchdog expired actual=%0d expected=0", cyc);
        finish_run();
    end

    initial begin
        int nop_before;
        // Exhaustive sequence sweep, free-running then stalled output.
        for (int bp = 0; bp < 2; bp++) begin
            bp_en = bp[0];
            for (int len = 1; len <= 6; len++) begin
                for (int pat = 0; pat < (1 << len); pat++) begin
                    do_reset();
                    for (int i = 0; i < len; i++) send(pat[i]);
                    do_flush();
                    drain_and_count();
                end
            end
        end
        bp_en = 1'b0;

        // R6: flush on an empty word emits nothing and adds no no-op.
        do_reset();
        send(1'b1); send(1'b1);
        drain_and_count();
        nop_before = nop_count;
        do_flush();
        repeat (2) @(negedge clk);
        chk(!out_valid, "R6 flush on empty word", 64'(out_valid), 64'd0);
        chk(nop_count == CW'(nop_before), "R6 no pad on empty flush", 64'(nop_count), 64'(nop_before));
        @(posedge clk); #2;

        // R6: flush raised together with in_valid has no effect.
        do_reset();
        send(1'b0);
        flush = 1'b1;
        send(1'b0);
        flush = 1'b0;
        repeat (2) @(negedge clk);
        chk(!out_valid, "R6 flush ignored with in_valid", 64'(out_valid), 64'd0);
        chk(nop_count == 0, "R6 flush ignored nop_count", 64'(nop_count), 64'd0);
        @(posedge clk); #2;
        send(1'b1);
        drain_and_count();

        // R8: instruction counter saturation.
        do_reset();
        for (int i = 0; i < 70; i++) send(1'b0);
        do_flush();
        drain_and_count();
        chk(insn_count == CW'(CMAX), "R8 insn_count saturates", 64'(insn_count), 64'(CMAX));

        // R9: no-op counter saturation through repeated splits.
        do_reset();
        for (int i = 0; i < 70; i++) begin send(1'b0); send(1'b1); end
        do_flush();
        drain_and_count();
        chk(nop_count == CW'(CMAX), "R9 nop_count saturates", 64'(nop_count), 64'(CMAX));

        finish_run();
    end
endmodule